// File: doc/BRIEF.md
# Shared-Pin General-Purpose I/O Controller

This block runs a bank of general-purpose I/O pins and lets each pin be lent to another function on the chip. Software uses four word registers on a simple on-chip peripheral bus. One holds the output levels, one the drive enables, one the per-bit open-drain mode, and one read-only register shows the synchronised pin levels. Every bus access finishes one cycle after it is presented, with a single ready pulse.

A per-pin select input, driven by a control register outside this block, decides who owns each pad. An owned pad takes its output and enable from the alternate function, such as a chip select or a trace output. Otherwise the GPIO registers drive it. Pins that are inputs to an alternate function, such as external interrupts, read the pad directly and simply keep their drive enable off. The highest pin cannot be lent and always belongs to the GPIO logic.

In open-drain mode a pin never drives high. A 0 pulls the pad low and a 1 releases it to high impedance, so several devices can share a wired-AND line.

Top module: `gpio_pinshare`

## Requirements
- R1: Each cycle in which `bus_sel` is high at a rising clock edge makes `bus_ready` high for exactly the following cycle, and `bus_rdata` is valid in that cycle. A cycle without `bus_sel` gives no ready. A write returns zero read data.
- R2: The output-level register is at byte offset 0x0, the drive-enable register at 0x4 and the open-drain register at 0x8. Each keeps the low `NUM_PINS` bits of a write and reads them back in bits `NUM_PINS-1:0`, with all upper read bits 0. A read returns the value held before any write in the same cycle.
- R3: A pin in GPIO mode with its open-drain bit clear drives `pad_out` equal to its output-level bit and `pad_oe` equal to its drive-enable bit (1 = drive).
- R4: A pin in GPIO mode with its open-drain bit set drives `pad_out` = 0. Its `pad_oe` is 1 only when the drive-enable bit is 1 and the output-level bit is 0, so a logic 1 releases the pad.
- R5: A shareable pin whose `alt_sel` bit is 1 copies `alt_out` and `alt_oe` to its pad. Its GPIO register contents are kept unchanged and take effect again once `alt_sel` returns to 0.
- R6: Offset 0xC reads the pad levels through a two-stage synchroniser. A level present on `pad_in` before rising edge k is returned by a read sampled at edge k+2.
- R7: Writes to the input register at 0xC change no register state.
- R8: Reads from any offset other than 0x0, 0x4, 0x8 and 0xC return 0, and writes to such offsets change no register state.
- R9: After reset, all three writable registers are 0, so every pin is an undriven GPIO input with open-drain off and output level 0, and `bus_ready` is 0.
- R10: Pin `NUM_PINS-1` ignores its `alt_sel`, `alt_out` and `alt_oe` bits and always follows the GPIO registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | One-cycle completion pulse |
| alt_sel | input | NUM_PINS (24) | Per-pin ownership, 1 = alternate function |
| alt_out | input | NUM_PINS (24) | Alternate-function output levels |
| alt_oe | input | NUM_PINS (24) | Alternate-function drive enables |
| pad_in | input | NUM_PINS (24) | Raw pad levels, asynchronous |
| pad_out | output | NUM_PINS (24) | Output level to the pads |
| pad_oe | output | NUM_PINS (24) | Drive enable to the pads, 1 = drive |

## Verification
The bench targets open-drain pins written with a 1. A design that drove the one would pull a shared line high instead of releasing it. It switches pins between GPIO and alternate ownership and back. A design that cleared or overwrote the registers on handover would come back with lost levels, and one that let the top pin be claimed would follow `alt_oe` there. It reads the input register while the pads toggle, so a missing or extra synchroniser stage shows as a one-cycle shift in the read value. It also writes to the input register and to unmapped offsets, where a loose address decoder would corrupt a real register.

// File: rtl/gpio_pinshare_pkg.sv
package gpio_pinshare_pkg;

    localparam logic [7:0] OFS_LEVEL = 8'h00;
    localparam logic [7:0] OFS_DRIVE = 8'h04;
    localparam logic [7:0] OFS_OPEND = 8'h08;
    localparam logic [7:0] OFS_SENSE = 8'h0C;

    typedef enum logic [2:0] {
        KIND_LEVEL,
        KIND_DRIVE,
        KIND_OPEND,
        KIND_SENSE,
        KIND_NONE
    } reg_kind_e;

    function automatic reg_kind_e decode_offset(input logic [7:0] ofs);
        case (ofs)
            OFS_LEVEL: return KIND_LEVEL;
            OFS_DRIVE: return KIND_DRIVE;
            OFS_OPEND: return KIND_OPEND;
            OFS_SENSE: return KIND_SENSE;
            default:   return KIND_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_pinshare_sync.sv
module gpio_pinshare_sync #(
    parameter int N      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_raw,
    output logic [N-1:0] pin_sync
);
    logic [N-1:0] stage_d [STAGES];
    logic [N-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = pin_raw;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < STAGES; s++) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_d[s];
        end
    end

    assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pinshare_regs.sv
module gpio_pinshare_regs
    import gpio_pinshare_pkg::*;
#(
    parameter int N      = 24,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      wdata_lo,
    input  logic [N-1:0]      pin_sync,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N-1:0]      level_q,
    output logic [N-1:0]      drive_q,
    output logic [N-1:0]      opend_q
);
    typedef struct packed {
        logic [N-1:0]      level;
        logic [N-1:0]      drive;
        logic [N-1:0]      opend;
        logic              rdy;
        logic [DATA_W-1:0] rdat;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        reg_kind_e kind;
        kind = decode_offset(8'(bus_addr));
        st_d      = st_q;
        st_d.rdy  = bus_sel;
        st_d.rdat = '0;
        if (bus_sel) begin
            if (!bus_wr) begin
                case (kind)
                    KIND_LEVEL: st_d.rdat = DATA_W'(st_q.level);
                    KIND_DRIVE: st_d.rdat = DATA_W'(st_q.drive);
                    KIND_OPEND: st_d.rdat = DATA_W'(st_q.opend);
                    KIND_SENSE: st_d.rdat = DATA_W'(pin_sync);
                    default:    st_d.rdat = '0;
                endcase
            end else begin
                case (kind)
                    KIND_LEVEL: st_d.level = wdata_lo;
                    KIND_DRIVE: st_d.drive = wdata_lo;
                    KIND_OPEND: st_d.opend = wdata_lo;
                    default:    ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_ready = st_q.rdy;
    assign bus_rdata = st_q.rdat;
    assign level_q   = st_q.level;
    assign drive_q   = st_q.drive;
    assign opend_q   = st_q.opend;
endmodule

// File: rtl/gpio_pinshare_padmux.sv
module gpio_pinshare_padmux #(
    parameter int           N          = 24,
    parameter logic [N-1:0] SHARE_MASK = {1'b0, {(N-1){1'b1}}}
) (
    input  logic [N-1:0] level_q,
    input  logic [N-1:0] drive_q,
    input  logic [N-1:0] opend_q,
    input  logic [N-1:0] alt_sel,
    input  logic [N-1:0] alt_out,
    input  logic [N-1:0] alt_oe,
    output logic [N-1:0] pad_out,
    output logic [N-1:0] pad_oe
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic gpio_out, gpio_oe, give_away;
        assign gpio_out  = level_q[i] & ~opend_q[i];
        assign gpio_oe   = drive_q[i] & ~(opend_q[i] & level_q[i]);
        if (SHARE_MASK[i]) begin : g_shared
            assign give_away = alt_sel[i];
        end else begin : g_fixed
            logic unused_alt;
            assign unused_alt = alt_sel[i];
            assign give_away  = 1'b0;
        end
        assign pad_out[i] = give_away ? alt_out[i] : gpio_out;
        assign pad_oe[i]  = give_away ? alt_oe[i]  : gpio_oe;
    end
endmodule

// File: rtl/gpio_pinshare.sv
module gpio_pinshare #(
    parameter int                  NUM_PINS    = 24,
    parameter int                  ADDR_W      = 4,
    parameter int                  DATA_W      = 32,
    parameter int                  SYNC_STAGES = 2,
    parameter logic [NUM_PINS-1:0] SHARE_MASK  = {1'b0, {(NUM_PINS-1){1'b1}}}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_ready,
    input  logic [NUM_PINS-1:0] alt_sel,
    input  logic [NUM_PINS-1:0] alt_out,
    input  logic [NUM_PINS-1:0] alt_oe,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] reg_level, reg_drive, reg_opend;
    logic                unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_PINS];

    gpio_pinshare_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pad_in),
        .pin_sync (pin_sync)
    );

    gpio_pinshare_regs #(.N(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .wdata_lo  (bus_wdata[NUM_PINS-1:0]),
        .pin_sync  (pin_sync),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .level_q   (reg_level),
        .drive_q   (reg_drive),
        .opend_q   (reg_opend)
    );

    gpio_pinshare_padmux #(.N(NUM_PINS), .SHARE_MASK(SHARE_MASK)) u_padmux (
        .level_q (reg_level),
        .drive_q (reg_drive),
        .opend_q (reg_opend),
        .alt_sel (alt_sel),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );
endmodule

// File: rtl/gpio_pinshare_chk.sv
module gpio_pinshare_chk #(
    parameter int                  NUM_PINS   = 24,
    parameter int                  ADDR_W     = 4,
    parameter int                  DATA_W     = 32,
    parameter logic [NUM_PINS-1:0] SHARE_MASK = {1'b0, {(NUM_PINS-1){1'b1}}}
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                bus_ready,
    input logic [NUM_PINS-1:0] alt_sel,
    input logic [NUM_PINS-1:0] alt_out,
    input logic [NUM_PINS-1:0] alt_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] reg_level,
    input logic [NUM_PINS-1:0] reg_drive,
    input logic [NUM_PINS-1:0] reg_opend
);
    logic [NUM_PINS-1:0] lent;
    logic                hit_sense, hit_none;

    assign lent      = alt_sel & SHARE_MASK;
    assign hit_sense = (8'(bus_addr) == 8'h0C);
    assign hit_none  = (8'(bus_addr) != 8'h00) && (8'(bus_addr) != 8'h04) &&
                       (8'(bus_addr) != 8'h08) && (8'(bus_addr) != 8'h0C);

    // R1
    ready_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> bus_ready);

    // R1
    no_spurious_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !bus_ready);

    // R2
    upper_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> (bus_rdata[DATA_W-1:NUM_PINS] == '0));

    // R4
    opend_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_opend & ~lent & pad_oe & pad_out) == '0));

    // R5
    alt_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lent & ((pad_oe ^ alt_oe) | (pad_out ^ alt_out))) == '0));

    // R7
    sense_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && hit_sense) |=>
            ($stable(reg_level) && $stable(reg_drive) && $stable(reg_opend)));

    // R8
    unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && hit_none) |=>
            ($stable(reg_level) && $stable(reg_drive) && $stable(reg_opend)));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reg_level == '0 && reg_drive == '0 && reg_opend == '0 && !bus_ready));

    // R10
    fixed_pin_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~SHARE_MASK & ~reg_drive & pad_oe) == '0));
endmodule

bind gpio_pinshare gpio_pinshare_chk #(
    .NUM_PINS   (NUM_PINS),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SHARE_MASK (SHARE_MASK)
) u_chk (.*);

// File: tb/gpio_pinshare_test.sv
module gpio_pinshare_test;
    localparam int NP = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_ready;
    logic [NP-1:0] alt_sel = '0, alt_out = '0, alt_oe = '0, pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    gpio_pinshare uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .alt_sel(alt_sel), .alt_out(alt_out),
        .alt_oe(alt_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Behavioural reference model
    logic [NP-1:0] m_level = '0, m_drive = '0, m_opend = '0;
    logic          m_ready = 1'b0;
    logic [31:0]   m_rdata = '0;
    logic [NP-1:0] m_hist[$] = '{24'h0, 24'h0};
    string         m_tag = "R9";
    bit            m_written = 1'b0;
    bit            m_last_sense_wr = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_level = '0; m_drive = '0; m_opend = '0;
            m_ready = 1'b0; m_rdata = '0;
            m_hist = '{24'h0, 24'h0};
            m_written = 1'b0;
        end else begin
            m_ready = bus_sel;
            m_rdata = '0;
            if (bus_sel && !bus_wr) begin
                case (bus_addr)
                    4'h0: m_rdata = {8'h0, m_level};
                    4'h4: m_rdata = {8'h0, m_drive};
                    4'h8: m_rdata = {8'h0, m_opend};
                    4'hC: m_rdata = {8'h0, m_hist[0]};
                    default: m_rdata = '0;
                endcase
                if (!m_written)                              m_tag = "R9";
                else if (bus_addr == 4'hC && m_last_sense_wr) m_tag = "R7";
                else if (bus_addr == 4'hC)                    m_tag = "R6";
                else if (bus_addr inside {4'h0, 4'h4, 4'h8})  m_tag = "R2";
                else                                          m_tag = "R8";
            end else if (bus_sel) begin
                m_tag = "R1";
                m_written = 1'b1;
                m_last_sense_wr = (bus_addr == 4'hC);
                case (bus_addr)
                    4'h0: m_level = bus_wdata[NP-1:0];
                    4'h4: m_drive = bus_wdata[NP-1:0];
                    4'h8: m_opend = bus_wdata[NP-1:0];
                    default: ;
                endcase
            end
            m_hist.push_back(pad_in);
            void'(m_hist.pop_front());
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare every cycle, away from the clock edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [NP-1:0] eo, ee, m_alt, m_fix, m_od;
            for (int i = 0; i < NP; i++) begin
                m_alt[i] = (i < NP-1) && alt_sel[i];
                m_fix[i] = (i == NP-1);
                m_od[i]  = !m_alt[i] && m_opend[i];
                if (m_alt[i]) begin
                    eo[i] = alt_out[i]; ee[i] = alt_oe[i];
                end else if (m_opend[i]) begin
                    eo[i] = 1'b0; ee[i] = m_drive[i] && !m_level[i];
                end else begin
                    eo[i] = m_level[i]; ee[i] = m_drive[i];
                end
            end
            check((((pad_out ^ eo) | (pad_oe ^ ee)) & m_alt) == '0, "R5", "alt pads",
                  {8'h0, pad_oe & m_alt}, {8'h0, ee & m_alt});
            check((((pad_out ^ eo) | (pad_oe ^ ee)) & m_fix) == '0, "R10", "fixed pin",
                  {8'h0, pad_oe & m_fix}, {8'h0, ee & m_fix});
            check((((pad_out ^ eo) | (pad_oe ^ ee)) & m_od & ~m_fix) == '0, "R4", "open-drain pads",
                  {8'h0, pad_oe & m_od}, {8'h0, ee & m_od});
            check((((pad_out ^ eo) | (pad_oe ^ ee)) & ~m_alt & ~m_od & ~m_fix) == '0, "R3",
                  "push-pull pads", {8'h0, pad_out}, {8'h0, eo});
            check(bus_ready == m_ready, "R1", "ready", {31'h0, bus_ready}, {31'h0, m_ready});
            if (m_ready)
                check(bus_rdata == m_rdata, m_tag, "rdata", bus_rdata, m_rdata);
        end
    end

    task automatic bus_op(input bit wr, input logic [3:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(pad_oe == '0 && bus_ready == 1'b0, "R9", "reset pads/ready",
              {8'h0, pad_oe}, 32'h0);
        bus_op(0, 4'h0, 0); bus_op(0, 4'h4, 0); bus_op(0, 4'h8, 0); bus_op(0, 4'hC, 0);
        // push-pull
        bus_op(1, 4'h0, 32'hFFA5A5A5);
        bus_op(1, 4'h4, 32'h00FFFFFF);
        bus_op(0, 4'h0, 0); bus_op(0, 4'h4, 0);
        // open drain on alternate nibbles
        bus_op(1, 4'h8, 32'h000F0F0F);
        bus_op(0, 4'h8, 0);
        bus_op(1, 4'h0, 32'h00FFFFFF);
        bus_op(1, 4'h0, 32'h00000000);
        bus_op(1, 4'h0, 32'h00A5A5A5);
        // synchroniser
        @(negedge clk); pad_in = 24'h123456;
        bus_op(0, 4'hC, 0); bus_op(0, 4'hC, 0); bus_op(0, 4'hC, 0);
        pad_in = 24'hFEDCBA;
        bus_op(0, 4'hC, 0); bus_op(0, 4'hC, 0);
        // writes to the input register and unmapped offsets
        bus_op(1, 4'hC, 32'hFFFFFFFF); bus_op(0, 4'hC, 0);
        bus_op(1, 4'h2, 32'hFFFFFFFF); bus_op(1, 4'h6, 32'h0);
        bus_op(0, 4'h2, 0); bus_op(0, 4'hF, 0);
        bus_op(0, 4'h0, 0); bus_op(0, 4'h4, 0); bus_op(0, 4'h8, 0);
        // hand every pin to the alternate function, then back
        @(negedge clk); alt_sel = '1; alt_out = 24'h5A5A5A; alt_oe = 24'hFFFFFF;
        bus_op(1, 4'h4, 32'h007FFFFF);
        bus_op(0, 4'h0, 0);
        alt_out = 24'hC3C3C3; alt_oe = 24'h0F0F0F;
        repeat (3) @(negedge clk);
        alt_sel = 24'h000000;
        bus_op(0, 4'h0, 0); bus_op(0, 4'h4, 0); bus_op(0, 4'h8, 0);
        // back-to-back random traffic
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            bus_sel   = $urandom_range(0, 1);
            bus_wr    = $urandom_range(0, 1);
            bus_addr  = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'($urandom_range(0, 3) * 4);
            bus_wdata = $urandom;
            alt_sel   = NP'($urandom);
            alt_out   = NP'($urandom);
            alt_oe    = NP'($urandom);
            pad_in    = NP'($urandom);
        end
        @(negedge clk); bus_sel = 1'b0;
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #40000;
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog run did not finish actual=%0d expected=0", 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule